// File: doc/BRIEF.md
# FIFO Threshold Offset Programmer

This block supplies the two threshold offsets a FIFO flag generator compares against: how close to empty counts as "almost empty", and how close to full counts as "almost full". The method of obtaining those offsets is captured once, while master reset is held. It is taken from two select pins and a serial-mode pin. Three select codes give a fixed offset, which is used for both thresholds. The fourth code hands control to user loading. User loading takes either bytes from a data bus on load strobes, or a bit stream on a dedicated serial input.

The captured method and the stored offsets persist until the next master reset. A partial reset, which flushes only the FIFO's pointers, leaves this block untouched. A `done_o` output tells the flag logic when both offsets hold valid values.

Top module: `fifo_offset_prog`

## Requirements
- R1: While `rst_ni` is low and after it rises, both offsets read 8 and `done_o` is 1. The method is fixed-default until the first master reset.
- R2: A clock edge with `mrst_i` high and `sel_i` = 2'b00, 2'b01 or 2'b10 sets both offsets to 8, 16 or 64 respectively and sets `done_o` to 1. The outputs show this after that edge.
- R3: A clock edge with `mrst_i` high and `sel_i` = 2'b11 selects user loading, clears both offsets to 0 and clears `done_o`. The loading style follows `ser_mode_i`: 1 selects serial loading and 0 selects parallel loading. When `mrst_i` is low, `sel_i` and `ser_mode_i` have no effect.
- R4: In parallel mode, alternating `load_i` strobes write `data_i` into the offsets. The first strobe after master reset writes almost-empty and the second writes almost-full, and the second also sets `done_o`. A third strobe writes almost-empty again. Each write is visible after the strobe's edge.
- R5: In serial mode, each edge with `ser_en_i` high takes one bit from `ser_d_i`. The first 8 bits form the almost-empty offset, MSB first, and the next 8 bits form the almost-full offset, MSB first. Both offsets and `done_o` = 1 appear after the 16th bit. Bits that arrive after that are ignored.
- R6: `prst_i` has no effect on the offsets, the captured method, the load sequence or `done_o`.
- R7: Load strobes and serial bits on an edge where `mrst_i` is high are ignored. Master reset restarts the load sequence.
- R8: Load strobes have no effect in the default and serial modes. Serial bits have no effect in the default and parallel modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mrst_i | input | 1 | Master reset, synchronous, active high; captures the method |
| prst_i | input | 1 | Partial reset, synchronous, active high (FIFO flush only) |
| sel_i | input | 2 | Offset select, sampled under master reset |
| ser_mode_i | input | 1 | 1 = serial user loading, 0 = parallel user loading |
| load_i | input | 1 | Parallel load strobe |
| data_i | input | OFF_W | Parallel offset data |
| ser_en_i | input | 1 | Serial bit enable |
| ser_d_i | input | 1 | Serial data bit |
| ae_off_o | output | OFF_W | Almost-empty offset |
| af_off_o | output | OFF_W | Almost-full offset |
| done_o | output | 1 | Offsets valid |

## Verification
The hardest states to reach from the ports are the ones where stimulus that does not apply to the current mode lands during a loading sequence. Examples are a strobe in the middle of a serial stream, a serial bit between two parallel strobes, a partial reset between the halves, and bits that arrive after the 16th. Every cycle, the random stimulus drives strobes, serial bits, partial resets and changes to the select pins independently. Master resets with random selects are interleaved, so each mode sees all of this traffic, including traffic while master reset is asserted. Directed sequences add a third parallel strobe and a known serial pattern followed by extra bits.

// File: rtl/fop_pkg.sv
package fop_pkg;
  typedef enum logic [1:0] {
    MODE_DEF = 2'd0,
    MODE_PAR = 2'd1,
    MODE_SER = 2'd2
  } mode_e;

  localparam logic [1:0] SEL_USER = 2'b11;
endpackage

// File: rtl/fop_mode_latch.sv
module fop_mode_latch
  import fop_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mrst_i,
  input  logic [1:0]       sel_i,
  input  logic             ser_mode_i,
  output mode_e            mode_o,
  output logic [OFF_W-1:0] dflt_o
);
  function automatic logic [OFF_W-1:0] dflt_of(input logic [1:0] s);
    case (s)
      2'b00:   return OFF_W'(1) << 3;
      2'b01:   return OFF_W'(1) << 4;
      2'b10:   return OFF_W'(1) << 6;
      default: return '0;
    endcase
  endfunction

  mode_e            mode_q;
  logic [OFF_W-1:0] dflt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_DEF;
      dflt_q <= OFF_W'(1) << 3;
    end else if (mrst_i) begin
      if (sel_i == SEL_USER) mode_q <= ser_mode_i ? MODE_SER : MODE_PAR;
      else                   mode_q <= MODE_DEF;
      dflt_q <= dflt_of(sel_i);
    end
  end

  assign mode_o = mode_q;
  assign dflt_o = dflt_q;

  // mode only moves under master reset
  assert_mode_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mrst_i |=> $stable(mode_q));
endmodule

// File: rtl/fop_par_loader.sv
module fop_par_loader #(
  parameter int OFF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [OFF_W-1:0] data_i,
  output logic [OFF_W-1:0] ae_o,
  output logic [OFF_W-1:0] af_o,
  output logic             done_o
);
  logic             ptr_q;
  logic [OFF_W-1:0] ae_q, af_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= 1'b0;
      ae_q   <= '0;
      af_q   <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      ptr_q  <= 1'b0;
      ae_q   <= '0;
      af_q   <= '0;
      done_q <= 1'b0;
    end else if (en_i && load_i) begin
      ptr_q <= ~ptr_q;
      if (!ptr_q) ae_q <= data_i;
      else begin
        af_q   <= data_i;
        done_q <= 1'b1;
      end
    end
  end

  assign ae_o   = ae_q;
  assign af_o   = af_q;
  assign done_o = done_q;

  assert_par_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(en_i && load_i)) |=> ($stable(ae_q) && $stable(af_q) && $stable(done_q)));
  assert_par_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && load_i && !ptr_q) |=> $stable(af_q));
endmodule

// File: rtl/fop_ser_loader.sv
module fop_ser_loader #(
  parameter int OFF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             ser_en_i,
  input  logic             ser_d_i,
  output logic [OFF_W-1:0] ae_o,
  output logic [OFF_W-1:0] af_o,
  output logic             done_o
);
  localparam int TOT   = 2 * OFF_W;
  localparam int CNT_W = $clog2(TOT + 1);

  logic [TOT-1:0]   sr_q;
  logic [TOT-1:0]   full;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] ae_q, af_q;
  logic             done_q;
  logic             take;

  assign take = en_i && ser_en_i && (cnt_q != CNT_W'(TOT));
  assign full = {sr_q[TOT-2:0], ser_d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      ae_q   <= '0;
      af_q   <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      ae_q   <= '0;
      af_q   <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      sr_q  <= full;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(TOT - 1)) begin
        ae_q   <= full[TOT-1:OFF_W];
        af_q   <= full[OFF_W-1:0];
        done_q <= 1'b1;
      end
    end
  end

  assign ae_o   = ae_q;
  assign af_o   = af_q;
  assign done_o = done_q;

  assert_ser_cnt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(TOT));
  assert_ser_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clr_i) |=> (done_q && $stable(ae_q) && $stable(af_q)));
  assert_ser_done_cnt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cnt_q == CNT_W'(TOT)));
endmodule

// File: rtl/fifo_offset_prog.sv
module fifo_offset_prog
  import fop_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mrst_i,
  input  logic             prst_i,
  input  logic [1:0]       sel_i,
  input  logic             ser_mode_i,
  input  logic             load_i,
  input  logic [OFF_W-1:0] data_i,
  input  logic             ser_en_i,
  input  logic             ser_d_i,
  output logic [OFF_W-1:0] ae_off_o,
  output logic [OFF_W-1:0] af_off_o,
  output logic             done_o
);
  mode_e            mode;
  logic [OFF_W-1:0] dflt;
  logic [OFF_W-1:0] par_ae, par_af, ser_ae, ser_af;
  logic             par_done, ser_done;

  fop_mode_latch #(.OFF_W(OFF_W)) u_mode (
    .clk_i, .rst_ni, .mrst_i, .sel_i, .ser_mode_i,
    .mode_o(mode), .dflt_o(dflt)
  );

  fop_par_loader #(.OFF_W(OFF_W)) u_par (
    .clk_i, .rst_ni, .clr_i(mrst_i), .en_i(mode == MODE_PAR),
    .load_i, .data_i, .ae_o(par_ae), .af_o(par_af), .done_o(par_done)
  );

  fop_ser_loader #(.OFF_W(OFF_W)) u_ser (
    .clk_i, .rst_ni, .clr_i(mrst_i), .en_i(mode == MODE_SER),
    .ser_en_i, .ser_d_i, .ae_o(ser_ae), .af_o(ser_af), .done_o(ser_done)
  );

  always_comb begin
    unique case (mode)
      MODE_PAR: begin ae_off_o = par_ae; af_off_o = par_af; done_o = par_done; end
      MODE_SER: begin ae_off_o = ser_ae; af_off_o = ser_af; done_o = ser_done; end
      default:  begin ae_off_o = dflt;   af_off_o = dflt;   done_o = 1'b1;     end
    endcase
  end

  assert_dflt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrst_i && sel_i != SEL_USER) |=>
      (done_o && ae_off_o == af_off_o && $countones(ae_off_o) == 1));
  assert_user_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrst_i && sel_i == SEL_USER) |=> (!done_o && ae_off_o == '0 && af_off_o == '0));
  assert_prst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prst_i && !mrst_i && !load_i && !ser_en_i) |=>
      ($stable(ae_off_o) && $stable(af_off_o) && $stable(done_o)));
  assert_done_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mrst_i) |=> done_o);
endmodule

// File: tb/fifo_offset_prog_bench.sv
module fifo_offset_prog_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mrst = 1'b0, prst = 1'b0, ser_mode = 1'b0, load = 1'b0;
  logic         ser_en = 1'b0, ser_d = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic [W-1:0] data = '0;
  logic [W-1:0] ae_off, af_off;
  logic         done;

  int total = 0, bad = 0;

  // model state: 0 default, 1 parallel, 2 serial
  int           m_mode = 0;
  logic [W-1:0] m_ae = 8, m_af = 8, m_dflt = 8;
  logic         m_done = 1'b1, m_ptr = 1'b0;
  int           m_cnt = 0;
  logic [2*W-1:0] m_sr = '0;

  always #5ns clk = ~clk;

  fifo_offset_prog #(.OFF_W(W)) u_fifo_offset_prog (
    .clk_i(clk), .rst_ni(rst_n), .mrst_i(mrst), .prst_i(prst), .sel_i(sel),
    .ser_mode_i(ser_mode), .load_i(load), .data_i(data), .ser_en_i(ser_en),
    .ser_d_i(ser_d), .ae_off_o(ae_off), .af_off_o(af_off), .done_o(done)
  );

  function automatic logic [W-1:0] dflt_val(input logic [1:0] s);
    case (s)
      2'b00: return 8;
      2'b01: return 16;
      2'b10: return 64;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int md);
    case (md)
      1: return "R4/R8";
      2: return "R5/R8";
      default: return "R2/R8";
    endcase
  endfunction

  task automatic model_step();
    logic [2*W-1:0] f;
    if (mrst) begin
      m_mode = (sel == 2'b11) ? (ser_mode ? 2 : 1) : 0;
      m_dflt = dflt_val(sel);
      m_ptr = 1'b0; m_cnt = 0; m_sr = '0;
      m_done = (m_mode == 0);
      m_ae = (m_mode == 0) ? m_dflt : '0;
      m_af = m_ae;
    end else if (m_mode == 1 && load) begin
      if (!m_ptr) m_ae = data;
      else begin m_af = data; m_done = 1'b1; end
      m_ptr = ~m_ptr;
    end else if (m_mode == 2 && ser_en && m_cnt < 2*W) begin
      f = {m_sr[2*W-2:0], ser_d};
      m_sr = f;
      m_cnt++;
      if (m_cnt == 2*W) begin m_ae = f[2*W-1:W]; m_af = f[W-1:0]; m_done = 1'b1; end
    end
  endtask

  task automatic check(input string tag);
    total++;
    if (ae_off !== m_ae || af_off !== m_af || done !== m_done) begin
      bad++;
      $display("FAIL %s: ae=%0d af=%0d done=%0b expected ae=%0d af=%0d done=%0b",
               tag, ae_off, af_off, done, m_ae, m_af, m_done);
    end
  endtask

  // inputs already set after a negedge; clock one edge, check at next negedge
  task automatic cyc(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle();
    mrst = 0; prst = 0; load = 0; ser_en = 0; ser_d = 0;
  endtask

  task automatic do_mrst(input logic [1:0] s, input logic sm, input string tag);
    idle(); mrst = 1; sel = s; ser_mode = sm;
    load = 1; ser_en = 1; ser_d = 1; data = 8'hEE;  // R7: ignored under master reset
    cyc(tag);
    idle();
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    do_mrst(2'b00, 0, "R2/R7 sel00");
    do_mrst(2'b01, 1, "R2/R7 sel01");
    do_mrst(2'b10, 0, "R2/R7 sel10");
    load = 1; data = 8'h33; cyc("R8 strobe in default");
    ser_en = 1; ser_d = 1; cyc("R8 bit in default");
    idle(); sel = 2'b00; cyc("R3 sel ignored outside master reset");

    // parallel directed
    do_mrst(2'b11, 0, "R3/R7 parallel entry");
    load = 1; data = 8'd5;  cyc("R4 first strobe");
    idle(); ser_en = 1; ser_d = 1; prst = 1; cyc("R6/R8 between strobes");
    idle(); load = 1; data = 8'd200; cyc("R4 second strobe");
    data = 8'd9; cyc("R4 third strobe");
    idle(); prst = 1; cyc("R6 prst parallel");

    // serial directed: A5 then 3C then extra bits
    do_mrst(2'b11, 1, "R3/R7 serial entry");
    for (int i = 0; i < 2*W + 3; i++) begin
      logic [2*W-1:0] pat = 16'hA53C;
      ser_en = 1; ser_d = (i < 2*W) ? pat[2*W-1-i] : 1'b0;
      load = (i == 4); prst = (i == 7); data = 8'hFF;
      cyc(i < 2*W ? "R5/R6/R8 serial stream" : "R5 extra bits");
    end
    idle();
    if (ae_off !== 8'hA5 || af_off !== 8'h3C) begin
      bad++; total++;
      $display("FAIL R5: ae=%0h af=%0h expected ae=a5 af=3c", ae_off, af_off);
    end else total++;

    // constrained random
    for (int s = 0; s < 60; s++) begin
      logic [1:0] rs = ($urandom % 2) ? 2'b11 : 2'($urandom % 3);
      do_mrst(rs, 1'($urandom), "R2/R3/R7 random mrst");
      for (int c = 0; c < 20 + ($urandom % 40); c++) begin
        mrst = (($urandom % 40) == 0);
        prst = (($urandom % 6) == 0);
        load = (($urandom % 4) == 0);
        ser_en = (($urandom % 2) == 0);
        ser_d = 1'($urandom);
        data = W'($urandom);
        sel = 2'($urandom);
        ser_mode = 1'($urandom);
        cyc(mrst ? "R7 random" : (prst ? "R6 random" : tag_of(m_mode)));
      end
      idle();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2ms;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule